// File: doc/BRIEF.md
# Quadrature Encoder Position and Speed Capture Unit

This block turns the two square-wave phases of an incremental motor encoder into a signed position count. It also takes timed snapshots of that count for speed and position control loops. Both phases are synchronized to the system clock. Every edge of either phase is decoded as one step, up or down, of a 16-bit position counter.

A free-running 16-bit reference counter runs beside the position counter and is compared against two programmable period values. When the reference counter reaches the position period it returns to zero, and the position count is snapshotted. When it reaches the speed period, the position count is also snapshotted, but the counter keeps running.

In the opposite direction, every decoded encoder step snapshots the reference counter, which gives the time between steps. The value captured before it is shifted into a buffer register, so control software always sees the latest interval and the one before it.

Top module: `qenc_capture_unit`

## Requirements
- R1: Each phase input goes through a two-flop synchronizer. A change applied between clock edges first shows on `posCount` right after the third rising edge that follows the change. After two edges `posCount` still holds its old value.
- R2: A leading B is decoded as counting up, with each edge of either phase giving +1. The phase states follow the order (A,B) = 00, 10, 11, 01, 00. After such a step `dirUp` reads 1.
- R3: B leading A is decoded as counting down, with each edge giving -1. The phase states follow the order (A,B) = 00, 01, 11, 10, 00. After such a step `dirUp` reads 0.
- R4: `posCount` is 16 bits wide and wraps silently: one down step from 0 gives 0xFFFF, and one up step from 0xFFFF gives 0.
- R5: When both phases change in the same synchronized sample, no count takes place and no width capture occurs. `phaseError` is set and stays at 1 until reset, even if valid steps follow.
- R6: `refCount` increments every cycle. In the cycle after it equals `posPeriod`, it reads 0. Position snapshots are therefore spaced `posPeriod`+1 cycles apart.
- R7: In the cycle after `refCount` equals `speedPeriod`, `speedCapValid` pulses for one cycle. `speedCap` then holds the `posCount` of the matching cycle, and `refCount` keeps counting without clearing.
- R8: In the cycle after `refCount` equals `posPeriod`, `posCapValid` pulses for one cycle, and `posCap` holds the `posCount` of the matching cycle.
- R9: Each decoded step pulses `widthCapValid` for one cycle. The pulse comes in the same cycle in which `posCount` shows the new value. `widthCap` then holds the `refCount` of the cycle in which the step was decoded.
- R10: On each width capture, `widthBuf` takes the value that `widthCap` held before the capture. Both registers read 0 after reset.
- R11: While reset is held low, all counters, captures, strobes, `dirUp` and `phaseError` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| speedPeriod | input | 16 | Reference count that triggers the speed snapshot |
| posPeriod | input | 16 | Reference count that triggers the position snapshot and the counter clear |
| posCount | output | 16 | Up/down position counter |
| refCount | output | 16 | Reference counter |
| speedCap | output | 16 | Position count taken at the speed match |
| speedCapValid | output | 1 | One-cycle strobe for a new speed snapshot |
| posCap | output | 16 | Position count taken at the position match |
| posCapValid | output | 1 | One-cycle strobe for a new position snapshot |
| widthCap | output | 16 | Reference count at the latest encoder step |
| widthBuf | output | 16 | Previous value of widthCap |
| widthCapValid | output | 1 | One-cycle strobe for a new width capture |
| dirUp | output | 1 | Direction of the last valid step (1 = up) |
| phaseError | output | 1 | Sticky flag for a simultaneous change on both phases |

## Verification
The bench starts at count zero and steps down once so that the counter wraps to 0xFFFF, then steps back up through zero. A design that truncates the count wrongly or saturates would miss either value. It samples `posCount` two and three cycles after each phase change. A synchronizer that is one flop short or one flop long shifts the change into the wrong sample.

A double-phase change is injected in the middle of the run. A decoder that treats it as a step would enqueue no expected item yet produce a width capture, which the scoreboard reports. A flag that is not sticky fails on the later valid steps. Every width, speed and position capture is compared with the values the bench saw on the ports one cycle earlier. This catches a buffer that copies the new value instead of the old one, a snapshot that is late by one cycle, or a speed match that wrongly clears the reference counter.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic cntEn;    // one valid quadrature step decoded
    logic cntUp;    // direction of that step
    logic phaseErr; // both phases moved in the same sample
    logic speedHit; // reference counter equals speed period
    logic posHit;   // reference counter equals position period
  } qenc_strobe_t;
endpackage

// File: rtl/qenc_sync.sv
module qenc_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int LAST = STAGES - 1;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], asyncIn[gi]};
      end
      assign syncOut[gi] = chain[LAST];
    end
  endgenerate
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             aSync,
  input  logic             bSync,
  input  logic [CNT_W-1:0] refCount,
  input  logic [CNT_W-1:0] speedPeriod,
  input  logic [CNT_W-1:0] posPeriod,
  output qenc_strobe_t     strobe
);
  logic aPrev, bPrev;
  logic chA, chB;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aPrev <= 1'b0;
      bPrev <= 1'b0;
    end else begin
      aPrev <= aSync;
      bPrev <= bSync;
    end
  end

  assign chA = aSync ^ aPrev;
  assign chB = bSync ^ bPrev;

  always_comb begin
    strobe          = '0;
    strobe.cntEn    = chA ^ chB;
    strobe.phaseErr = chA & chB;
    // A moved: up when phases now differ; B moved: up when phases now match
    strobe.cntUp    = chA ? (aSync != bSync) : (aSync == bSync);
    strobe.speedHit = (refCount == speedPeriod);
    strobe.posHit   = (refCount == posPeriod);
  end
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  qenc_strobe_t     strobe,
  output logic [CNT_W-1:0] posCount,
  output logic [CNT_W-1:0] refCount,
  output logic [CNT_W-1:0] speedCap,
  output logic             speedCapValid,
  output logic [CNT_W-1:0] posCap,
  output logic             posCapValid,
  output logic [CNT_W-1:0] widthCap,
  output logic [CNT_W-1:0] widthBuf,
  output logic             widthCapValid,
  output logic             dirUp,
  output logic             phaseError
);
  // position counter and direction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      posCount   <= '0;
      dirUp      <= 1'b0;
      phaseError <= 1'b0;
    end else begin
      if (strobe.cntEn) begin
        posCount <= strobe.cntUp ? posCount + 1'b1 : posCount - 1'b1;
        dirUp    <= strobe.cntUp;
      end
      if (strobe.phaseErr) phaseError <= 1'b1;
    end
  end

  // reference counter, cleared by the position period
  always_ff @(posedge clk) begin
    if (!rstN)              refCount <= '0;
    else if (strobe.posHit) refCount <= '0;
    else                    refCount <= refCount + 1'b1;
  end

  // period snapshots of the position count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      speedCap      <= '0;
      posCap        <= '0;
      speedCapValid <= 1'b0;
      posCapValid   <= 1'b0;
    end else begin
      speedCapValid <= strobe.speedHit;
      posCapValid   <= strobe.posHit;
      if (strobe.speedHit) speedCap <= posCount;
      if (strobe.posHit)   posCap   <= posCount;
    end
  end

  // step-interval capture with one-deep buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      widthCap      <= '0;
      widthBuf      <= '0;
      widthCapValid <= 1'b0;
    end else begin
      widthCapValid <= strobe.cntEn;
      if (strobe.cntEn) begin
        widthBuf <= widthCap;
        widthCap <= refCount;
      end
    end
  end
endmodule

// File: rtl/qenc_capture_unit.sv
module qenc_capture_unit
  import qenc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseA,
  input  logic             phaseB,
  input  logic [CNT_W-1:0] speedPeriod,
  input  logic [CNT_W-1:0] posPeriod,
  output logic [CNT_W-1:0] posCount,
  output logic [CNT_W-1:0] refCount,
  output logic [CNT_W-1:0] speedCap,
  output logic             speedCapValid,
  output logic [CNT_W-1:0] posCap,
  output logic             posCapValid,
  output logic [CNT_W-1:0] widthCap,
  output logic [CNT_W-1:0] widthBuf,
  output logic             widthCapValid,
  output logic             dirUp,
  output logic             phaseError
);
  logic [1:0]   phSync;
  qenc_strobe_t strobe;

  qenc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({phaseB, phaseA}),
    .syncOut(phSync)
  );

  qenc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .aSync(phSync[0]), .bSync(phSync[1]),
    .refCount(refCount),
    .speedPeriod(speedPeriod), .posPeriod(posPeriod),
    .strobe(strobe)
  );

  qenc_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .posCount(posCount), .refCount(refCount),
    .speedCap(speedCap), .speedCapValid(speedCapValid),
    .posCap(posCap), .posCapValid(posCapValid),
    .widthCap(widthCap), .widthBuf(widthBuf), .widthCapValid(widthCapValid),
    .dirUp(dirUp), .phaseError(phaseError)
  );
endmodule

// File: rtl/qenc_checker.sv
module qenc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] posCount,
  input logic [CNT_W-1:0] refCount,
  input logic [CNT_W-1:0] speedCap,
  input logic             speedCapValid,
  input logic [CNT_W-1:0] posCap,
  input logic             posCapValid,
  input logic [CNT_W-1:0] widthCap,
  input logic [CNT_W-1:0] widthBuf,
  input logic             widthCapValid,
  input logic             phaseError
);
  // R6: a position snapshot coincides with the cleared reference counter
  p_ref_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    posCapValid |-> refCount == '0);

  // R7: speed snapshot holds the count of the matching cycle
  p_speed_snap_r7: assert property (@(posedge clk) disable iff (!rstN)
    speedCapValid |-> speedCap == $past(posCount));

  // R8: position snapshot holds the count of the matching cycle
  p_pos_snap_r8: assert property (@(posedge clk) disable iff (!rstN)
    posCapValid |-> posCap == $past(posCount));

  // R10: buffer receives the previous capture
  p_width_buf_r10: assert property (@(posedge clk) disable iff (!rstN)
    widthCapValid |-> widthBuf == $past(widthCap));

  // R2 / R3: each capture marks a single step of one
  p_unit_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    widthCapValid |-> (posCount == CNT_W'($past(posCount) + 1'b1)) ||
                      (posCount == CNT_W'($past(posCount) - 1'b1)));

  // R5: position moves only together with a width capture
  p_hold_no_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    !widthCapValid |-> posCount == $past(posCount));

  // R5: error flag is sticky
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(phaseError) |-> phaseError);
endmodule

bind qenc_capture_unit qenc_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_qenc_capture_unit.sv
module tb_qenc_capture_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        phaseA = 1'b0, phaseB = 1'b0;
  logic [15:0] speedPeriod = 16'd15;
  logic [15:0] posPeriod   = 16'd40;
  logic [15:0] posCount, refCount, speedCap, posCap, widthCap, widthBuf;
  logic        speedCapValid, posCapValid, widthCapValid, dirUp, phaseError;

  int checks = 0, errors = 0;
  logic [15:0] expQ[$];
  logic [15:0] expCount = 16'd0;
  logic [15:0] prevRef = 16'd0, prevPos = 16'd0, lastWidth = 16'd0;
  int cyc = 0, lastPosCyc = -1, posSnaps = 0, speedSnaps = 0;
  logic curA = 1'b0, curB = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  qenc_capture_unit dut (
    .clk(clk), .rstN(rstN), .phaseA(phaseA), .phaseB(phaseB),
    .speedPeriod(speedPeriod), .posPeriod(posPeriod),
    .posCount(posCount), .refCount(refCount),
    .speedCap(speedCap), .speedCapValid(speedCapValid),
    .posCap(posCap), .posCapValid(posCapValid),
    .widthCap(widthCap), .widthBuf(widthBuf), .widthCapValid(widthCapValid),
    .dirUp(dirUp), .phaseError(phaseError)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: apply a phase state, enqueue the expected count, check timing
  task automatic applyPhase(input logic na, input logic nb, input string req);
    logic [15:0] oldCount;
    bit single;
    bit up;
    oldCount = expCount;
    single = (na != curA) ^ (nb != curB);
    up = (na != curA) ? (na != nb) : (na == nb);
    @(negedge clk);
    phaseA = na; phaseB = nb;
    curA = na; curB = nb;
    if (single) begin
      expCount = up ? expCount + 16'd1 : expCount - 16'd1;
      expQ.push_back(expCount);
    end
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(posCount == oldCount, "R1 early", posCount, oldCount);
    @(posedge clk); @(negedge clk);
    check(posCount == expCount, req, posCount, expCount);
    if (single) check(dirUp == up, req, dirUp, up);
    repeat (3) @(negedge clk);
  endtask

  task automatic stepUp(input string req);
    logic na, nb;
    na = ~curB; nb = curA;   // 00->10->11->01->00
    applyPhase(na, nb, req);
  endtask

  task automatic stepDown(input string req);
    logic na, nb;
    na = curB; nb = ~curA;   // 00->01->11->10->00
    applyPhase(na, nb, req);
  endtask

  // monitor: pops expected items on each capture and checks snapshots
  always @(negedge clk) begin
    if (rstN) begin
      if (widthCapValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R5 spurious width capture", 1, 0);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          check(posCount == e, "R9 count at capture", posCount, e);
        end
        check(widthCap == prevRef, "R9 width value", widthCap, prevRef);
        check(widthBuf == lastWidth, "R10 buffer", widthBuf, lastWidth);
        lastWidth = widthCap;
      end
      if (posCapValid) begin
        posSnaps++;
        check(prevRef == posPeriod, "R6 match point", prevRef, posPeriod);
        check(refCount == 16'd0, "R6 clear", refCount, 0);
        check(posCap == prevPos, "R8 position snapshot", posCap, prevPos);
        if (lastPosCyc >= 0)
          check(cyc - lastPosCyc == 41, "R6 interval", cyc - lastPosCyc, 41);
        lastPosCyc = cyc;
      end
      if (speedCapValid) begin
        speedSnaps++;
        check(prevRef == speedPeriod, "R7 match point", prevRef, speedPeriod);
        check(refCount == 16'(speedPeriod + 16'd1), "R7 no clear", refCount, speedPeriod + 16'd1);
        check(speedCap == prevPos, "R7 speed snapshot", speedCap, prevPos);
      end
      prevRef = refCount;
      prevPos = posCount;
      cyc++;
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(posCount == 0 && refCount == 0, "R11 counters", {posCount, refCount}, 0);
    check(speedCap == 0 && posCap == 0 && widthCap == 0 && widthBuf == 0, "R11 captures",
          {widthCap, widthBuf}, 0);
    check({speedCapValid, posCapValid, widthCapValid, dirUp, phaseError} == 5'b0, "R11 flags",
          {speedCapValid, posCapValid, widthCapValid, dirUp, phaseError}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    stepDown("R4 wrap down");          // 0 -> FFFF
    check(posCount == 16'hFFFF, "R4 wrap value", posCount, 16'hFFFF);
    check(dirUp == 1'b0, "R3 direction", dirUp, 0);
    stepUp("R4 wrap up");              // FFFF -> 0
    for (int i = 0; i < 8; i++) stepUp("R2 up step");
    check(posCount == 16'd8, "R2 up total", posCount, 8);
    for (int i = 0; i < 3; i++) stepDown("R3 down step");
    check(posCount == 16'd5, "R3 down total", posCount, 5);
    check(phaseError == 1'b0, "R5 no error yet", phaseError, 0);

    applyPhase(~curA, ~curB, "R5 double change");
    check(phaseError == 1'b1, "R5 error set", phaseError, 1);
    check(posCount == 16'd5, "R5 no count", posCount, 5);

    for (int i = 0; i < 4; i++) stepUp("R2 up after error");
    check(posCount == 16'd9, "R2 up after error total", posCount, 9);
    check(phaseError == 1'b1, "R5 sticky", phaseError, 1);
    stepDown("R3 reverse");
    stepUp("R2 reverse back");

    repeat (200) @(negedge clk);
    check(expQ.size() == 0, "R9 all steps captured", expQ.size(), 0);
    check(posSnaps >= 3, "R8 snapshots seen", posSnaps, 3);
    check(speedSnaps >= 3, "R7 snapshots seen", speedSnaps, 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule